// File: doc/BRIEF.md
# Snooping Cache Write-Back Responder

This block is the bus-side responder of a processor's write-back data cache when another master wants to look into it. An external arbiter asks for the bus with a hold request. The block gives the bus up one clock later. While it holds the bus off, the other master strobes snoop addresses into it. For each accepted snoop, the block reads the line state that a lookup port supplies. Two clocks after the strobe it drives a hit-to-modified flag that is active low. The flag goes low only for a modified line.

When the flag is low, the arbiter must take the hold request away. The block then becomes bus owner again and writes the dirty line back as a four-beat burst. The burst starts at line offset zero, and each beat advances the address by one 32-bit word. Further snoop strobes are ignored until the burst finishes. The flag returns high in the clock after the last transfer, and the block reports the line's next coherence state at that point.

The write-back goes ahead of any own access that the processor has waiting. A hold request that arrives during a burst is only acknowledged once the bus is idle again. The same applies to a hold request that arrives during a waiting own access.

Top module: `snoop_wb_resp`

## Requirements
- R1: While reset is asserted, hold_ack is 0, hitm_n is 1, ads_n is 1, blast_n is 1 and nxt_vld is 0.
- R2: With the bus idle and no write-back to start, hold_ack becomes 1 in the clock after hold_req is sampled 1. It returns to 0 in the clock after hold_req is sampled 0.
- R3: A snoop strobe (snp_strobe_n = 0) sampled with look_state = 2'b10 (modified) drives hitm_n to 0 in the second clock after the strobe.
- R4: While hitm_n is 0, further snoop strobes are ignored. They produce no next-state report and do not change the write-back address.
- R5: The write-back is four beats. The first address is the snoop address with its low 4 bits cleared, and each beat adds 4. Data word i is look_line[32*i+31:32*i]. blast_n is 0 only on the fourth beat. A beat completes when brdy_n or rdy_n is sampled 0.
- R6: The write-back starts with ads_n = 0, wr = 1 and cache_n = 0 for one clock. This happens only in the clock after hold_req is sampled 0 while a modified hit is pending.
- R7: hitm_n stays 0 through the burst and returns to 1 in the clock after the final transfer.
- R8: A pending own access (own_req = 1) is issued only after the write-back. It is a single transfer with ads_n = 0, wr = 0, cache_n = 1, blast_n = 0 and bus_addr = own_addr. own_done is 1 in its completing clock.
- R9: A hold request raised during a burst or during an own access is acknowledged one clock after that transfer sequence ends, never earlier.
- R10: When beats end on rdy_n instead of brdy_n, a hold request raised after ads_n keeps hold_ack at 0 until after the fourth beat.
- R11: When the write-back ends, nxt_vld pulses together with hitm_n returning to 1. nxt_state is 2'b01 (shared) if snp_inv was 0 and 2'b00 (invalid) if it was 1.
- R12: For a miss (look_state 2'b00) or a clean hit (2'b01), hitm_n stays 1. In the second clock after the strobe, nxt_vld pulses with nxt_state 2'b00 for a miss or snp_inv = 1, and 2'b01 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_req | input | 1 | Bus hold request from the arbiter |
| hold_ack | output | 1 | Bus released to the other master |
| snp_strobe_n | input | 1 | Snoop address strobe, active low |
| snp_inv | input | 1 | Snoop caused by a write (invalidate) |
| snp_addr | input | 32 | Snooped byte address |
| look_state | input | 2 | Lookup result: 00 miss, 01 clean, 10 modified |
| look_line | input | 128 | Line contents from the lookup |
| hitm_n | output | 1 | Hit-to-modified flag, active low |
| nxt_vld | output | 1 | Next line state report is valid |
| nxt_state | output | 2 | Next line state: 00 invalid, 01 shared |
| own_req | input | 1 | Own single read access is waiting |
| own_addr | input | 32 | Address of the own access |
| own_done | output | 1 | Own access completes this clock |
| ads_n | output | 1 | Address strobe, active low |
| wr | output | 1 | 1 write, 0 read |
| cache_n | output | 1 | Cacheable burst marker, active low |
| blast_n | output | 1 | Last transfer, active low |
| brdy_n | input | 1 | Burst ready, active low |
| rdy_n | input | 1 | Non-burst ready, active low |
| bus_addr | output | 32 | Bus address |
| bus_wdata | output | 32 | Bus write data |

## Verification
A corrupted snoop pipeline would show up at hitm_n in the second clock after a strobe, either as a missing low level or as a flag that never releases. It would also show as a nxt_vld pulse in the wrong clock. A wrong beat counter or address register would show in the first beat after ads_n, as a bus_addr or bus_wdata value off by one word or as blast_n low on the wrong beat. A broken arbitration state would show within one clock of the end of a transfer sequence. There, either hold_ack would rise too early or the own read would come out ahead of the write-back.

// File: rtl/snp_wb_pkg.sv
package snp_wb_pkg;
  localparam logic [1:0] LOOK_MISS  = 2'b00;
  localparam logic [1:0] LOOK_CLEAN = 2'b01;
  localparam logic [1:0] LOOK_MOD   = 2'b10;

  localparam logic [1:0] NS_INVALID = 2'b00;
  localparam logic [1:0] NS_SHARED  = 2'b01;

  typedef enum logic [1:0] {
    BUS_IDLE = 2'b00,
    BUS_WB   = 2'b01,
    BUS_OWN  = 2'b10
  } bus_e;
endpackage

// File: rtl/snp_pipe.sv
module snp_pipe
  import snp_wb_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int BEATS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                strobe_n,
  input  logic                inv,
  input  logic [AW-1:0]       addr,
  input  logic [1:0]          look,
  input  logic [BEATS*DW-1:0] line,
  input  logic                wb_done,
  output logic                hitm_n,
  output logic                wb_pend,
  output logic [AW-1:0]       wb_addr,
  output logic [BEATS*DW-1:0] wb_line,
  output logic                ns_vld,
  output logic [1:0]          ns
);
  localparam int            LINE_W    = BEATS * DW;
  localparam logic [AW-1:0] LINE_MASK = AW'(BEATS * DW / 8 - 1);

  logic              lock_q, lock_d;
  logic              s1_vld_q, s1_vld_d;
  logic [1:0]        s1_look_q, s1_look_d;
  logic              s1_inv_q, s1_inv_d;
  logic [AW-1:0]     s1_addr_q, s1_addr_d;
  logic [LINE_W-1:0] s1_line_q, s1_line_d;
  logic              pend_q, pend_d;
  logic              wbinv_q, wbinv_d;
  logic [AW-1:0]     wbaddr_q, wbaddr_d;
  logic [LINE_W-1:0] wbline_q, wbline_d;
  logic              nsv_q, nsv_d;
  logic [1:0]        ns_q, ns_d;

  logic accept;
  logic s1_mod;

  assign accept = !strobe_n && !lock_q;
  assign s1_mod = s1_vld_q && (s1_look_q == LOOK_MOD);

  always_comb begin
    s1_vld_d  = accept;
    s1_look_d = accept ? look : s1_look_q;
    s1_inv_d  = accept ? inv  : s1_inv_q;
    s1_addr_d = accept ? addr : s1_addr_q;
    s1_line_d = accept ? line : s1_line_q;

    lock_d = lock_q;
    if (accept && look == LOOK_MOD) lock_d = 1'b1;
    if (wb_done)                    lock_d = 1'b0;

    pend_d   = pend_q;
    wbinv_d  = wbinv_q;
    wbaddr_d = wbaddr_q;
    wbline_d = wbline_q;
    if (s1_mod) begin
      pend_d   = 1'b1;
      wbinv_d  = s1_inv_q;
      wbaddr_d = s1_addr_q & ~LINE_MASK;
      wbline_d = s1_line_q;
    end
    if (wb_done) pend_d = 1'b0;

    nsv_d = 1'b0;
    ns_d  = ns_q;
    if (wb_done) begin
      nsv_d = 1'b1;
      ns_d  = wbinv_q ? NS_INVALID : NS_SHARED;
    end else if (s1_vld_q && !s1_mod) begin
      nsv_d = 1'b1;
      ns_d  = (s1_inv_q || s1_look_q == LOOK_MISS) ? NS_INVALID : NS_SHARED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q    <= 1'b0;
      s1_vld_q  <= 1'b0;
      s1_look_q <= LOOK_MISS;
      s1_inv_q  <= 1'b0;
      s1_addr_q <= '0;
      s1_line_q <= '0;
      pend_q    <= 1'b0;
      wbinv_q   <= 1'b0;
      wbaddr_q  <= '0;
      wbline_q  <= '0;
      nsv_q     <= 1'b0;
      ns_q      <= NS_INVALID;
    end else begin
      lock_q    <= lock_d;
      s1_vld_q  <= s1_vld_d;
      s1_look_q <= s1_look_d;
      s1_inv_q  <= s1_inv_d;
      s1_addr_q <= s1_addr_d;
      s1_line_q <= s1_line_d;
      pend_q    <= pend_d;
      wbinv_q   <= wbinv_d;
      wbaddr_q  <= wbaddr_d;
      wbline_q  <= wbline_d;
      nsv_q     <= nsv_d;
      ns_q      <= ns_d;
    end
  end

  assign hitm_n  = ~pend_q;
  assign wb_pend = pend_q;
  assign wb_addr = wbaddr_q;
  assign wb_line = wbline_q;
  assign ns_vld  = nsv_q;
  assign ns      = ns_q;

  // R3: modified hit shows on the flag in the second clock
  p_hitm_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && look == LOOK_MOD) |=> ##1 !hitm_n);

  // R12: miss or clean hit keeps the flag high and reports a state
  p_clean_report_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && look != LOOK_MOD) |=> ##1 (hitm_n && ns_vld));

  // R4: the write-back address is frozen while the flag is low
  p_addr_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !hitm_n |=> (hitm_n || $stable(wb_addr)));
endmodule

// File: rtl/snp_bus_fsm.sv
module snp_bus_fsm
  import snp_wb_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int BEATS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hold_req,
  output logic                hold_ack,
  input  logic                wb_pend,
  input  logic [AW-1:0]       wb_addr,
  input  logic [BEATS*DW-1:0] wb_line,
  input  logic                own_req,
  input  logic [AW-1:0]       own_addr,
  input  logic                brdy_n,
  input  logic                rdy_n,
  output logic                wb_done,
  output logic                own_done,
  output logic                ads_n,
  output logic                wr,
  output logic                cache_n,
  output logic                blast_n,
  output logic [AW-1:0]       addr_out,
  output logic [DW-1:0]       data_out
);
  localparam int            BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int            BYTE_W = $clog2(DW / 8);
  localparam logic [AW-1:0] STEP   = AW'(DW / 8);

  bus_e              st_q, st_d;
  logic              first_q, first_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              ack_q, ack_d;
  logic [AW-1:0]     oaddr_q, oaddr_d;

  logic              xfer;
  logic              last;
  logic [DW-1:0]     word_a [BEATS];

  for (genvar g = 0; g < BEATS; g++) begin : g_word
    assign word_a[g] = wb_line[g*DW +: DW];
  end

  assign xfer     = !brdy_n || !rdy_n;
  assign last     = (beat_q == BEAT_W'(BEATS - 1));
  assign wb_done  = (st_q == BUS_WB) && last && xfer;
  assign own_done = (st_q == BUS_OWN) && xfer;

  always_comb begin
    st_d    = st_q;
    first_d = 1'b0;
    beat_d  = beat_q;
    ack_d   = ack_q;
    oaddr_d = oaddr_q;
    unique case (st_q)
      BUS_IDLE: begin
        if (wb_pend && !hold_req) begin
          st_d    = BUS_WB;
          first_d = 1'b1;
          beat_d  = '0;
          ack_d   = 1'b0;
        end else if (hold_req) begin
          ack_d = 1'b1;
        end else if (own_req) begin
          st_d    = BUS_OWN;
          first_d = 1'b1;
          ack_d   = 1'b0;
          oaddr_d = own_addr;
        end else begin
          ack_d = 1'b0;
        end
      end
      BUS_WB: begin
        if (xfer) begin
          if (last) st_d = BUS_IDLE;
          else      beat_d = beat_q + 1'b1;
        end
      end
      BUS_OWN: begin
        if (xfer) st_d = BUS_IDLE;
      end
      default: st_d = BUS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= BUS_IDLE;
      first_q <= 1'b0;
      beat_q  <= '0;
      ack_q   <= 1'b0;
      oaddr_q <= '0;
    end else begin
      st_q    <= st_d;
      first_q <= first_d;
      beat_q  <= beat_d;
      ack_q   <= ack_d;
      oaddr_q <= oaddr_d;
    end
  end

  assign hold_ack = ack_q;
  assign ads_n    = ~first_q;
  assign wr       = (st_q == BUS_WB);
  assign cache_n  = ~(st_q == BUS_WB);
  assign blast_n  = ~(((st_q == BUS_WB) && last) || (st_q == BUS_OWN));
  assign addr_out = (st_q == BUS_WB)
                    ? (wb_addr | {{(AW-BEAT_W-BYTE_W){1'b0}}, beat_q, {BYTE_W{1'b0}}})
                    : ((st_q == BUS_OWN) ? oaddr_q : '0);
  assign data_out = (st_q == BUS_WB) ? word_a[beat_q] : '0;

  // R5: burst opens at line offset zero
  p_burst_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ads_n && wr) |-> (addr_out[BEAT_W+BYTE_W-1:0] == '0));

  // R5: each completed non-final beat advances the address by one word
  p_beat_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && xfer && blast_n) |=> (wr && addr_out == $past(addr_out) + STEP));

  // R6: write-back opens only after the hold request was low
  p_hold_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ads_n && wr) |-> (!cache_n && !$past(hold_req)));

  // R10: no acknowledge while the burst is on the bus
  p_ack_low_in_burst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> !hold_ack);

  // R2: acknowledge follows a sampled request
  p_ack_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_ack) |-> $past(hold_req));

  // R2: acknowledge drops one clock after the request is gone
  p_ack_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_ack && !hold_req) |=> !hold_ack);
endmodule

// File: rtl/snoop_wb_resp.sv
module snoop_wb_resp
  import snp_wb_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int BEATS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hold_req,
  output logic                hold_ack,
  input  logic                snp_strobe_n,
  input  logic                snp_inv,
  input  logic [AW-1:0]       snp_addr,
  input  logic [1:0]          look_state,
  input  logic [BEATS*DW-1:0] look_line,
  output logic                hitm_n,
  output logic                nxt_vld,
  output logic [1:0]          nxt_state,
  input  logic                own_req,
  input  logic [AW-1:0]       own_addr,
  output logic                own_done,
  output logic                ads_n,
  output logic                wr,
  output logic                cache_n,
  output logic                blast_n,
  input  logic                brdy_n,
  input  logic                rdy_n,
  output logic [AW-1:0]       bus_addr,
  output logic [DW-1:0]       bus_wdata
);
  logic                rst_meta_q, rst_sync_q;
  logic                wb_pend, wb_done;
  logic [AW-1:0]       wb_addr;
  logic [BEATS*DW-1:0] wb_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  snp_pipe #(.AW(AW), .DW(DW), .BEATS(BEATS)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .strobe_n (snp_strobe_n),
    .inv      (snp_inv),
    .addr     (snp_addr),
    .look     (look_state),
    .line     (look_line),
    .wb_done  (wb_done),
    .hitm_n   (hitm_n),
    .wb_pend  (wb_pend),
    .wb_addr  (wb_addr),
    .wb_line  (wb_line),
    .ns_vld   (nxt_vld),
    .ns       (nxt_state)
  );

  snp_bus_fsm #(.AW(AW), .DW(DW), .BEATS(BEATS)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .hold_req (hold_req),
    .hold_ack (hold_ack),
    .wb_pend  (wb_pend),
    .wb_addr  (wb_addr),
    .wb_line  (wb_line),
    .own_req  (own_req),
    .own_addr (own_addr),
    .brdy_n   (brdy_n),
    .rdy_n    (rdy_n),
    .wb_done  (wb_done),
    .own_done (own_done),
    .ads_n    (ads_n),
    .wr       (wr),
    .cache_n  (cache_n),
    .blast_n  (blast_n),
    .addr_out (bus_addr),
    .data_out (bus_wdata)
  );

  // R7: flag releases in the clock after the final write-back transfer
  p_hitm_release_r7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (wr && !blast_n && (!brdy_n || !rdy_n)) |=> hitm_n);

  // R8: no own access goes out while a dirty line is still owed
  p_wb_first_r8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (!ads_n && !wr) |-> hitm_n);

  // R9: acknowledge only rises after a clock with no transfer in flight
  p_ack_after_bus_r9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(hold_ack) |-> $past(ads_n && blast_n && !wr));
endmodule

// File: tb/snoop_wb_resp_bench.sv
module snoop_wb_resp_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         hold_req, hold_ack;
  logic         snp_strobe_n, snp_inv;
  logic [31:0]  snp_addr;
  logic [1:0]   look_state;
  logic [127:0] look_line;
  logic         hitm_n, nxt_vld;
  logic [1:0]   nxt_state;
  logic         own_req, own_done;
  logic [31:0]  own_addr;
  logic         ads_n, wr, cache_n, blast_n, brdy_n, rdy_n;
  logic [31:0]  bus_addr, bus_wdata;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  always #2 clk = ~clk;

  snoop_wb_resp u_snoop_wb_resp (
    .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .hold_ack(hold_ack),
    .snp_strobe_n(snp_strobe_n), .snp_inv(snp_inv), .snp_addr(snp_addr),
    .look_state(look_state), .look_line(look_line), .hitm_n(hitm_n),
    .nxt_vld(nxt_vld), .nxt_state(nxt_state), .own_req(own_req),
    .own_addr(own_addr), .own_done(own_done), .ads_n(ads_n), .wr(wr),
    .cache_n(cache_n), .blast_n(blast_n), .brdy_n(brdy_n), .rdy_n(rdy_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] mk_line(input logic [31:0] seed);
    return {seed + 32'd3, seed + 32'd2, seed + 32'd1, seed};
  endfunction

  task automatic snoop(input logic [1:0] st, input logic iv, input logic [31:0] a,
                       input logic [127:0] ln);
    snp_strobe_n = 1'b0; look_state = st; snp_inv = iv; snp_addr = a; look_line = ln;
  endtask

  task automatic get_hold();
    hold_req = 1'b1; step(); step();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    hold_req = 0; snp_strobe_n = 1; snp_inv = 0; snp_addr = 0; look_state = 0;
    look_line = 0; own_req = 0; own_addr = 0; brdy_n = 1; rdy_n = 1;
    step(); step();
    chk("R1 hold_ack", hold_ack, 0);
    chk("R1 hitm_n", hitm_n, 1);
    chk("R1 ads_n", ads_n, 1);
    chk("R1 blast_n", blast_n, 1);
    chk("R1 nxt_vld", nxt_vld, 0);
    rst_n = 1'b1;
    repeat (4) step();
  endtask

  task automatic t_hold();
    hold_req = 1'b1;
    chk("R2 ack before sample", hold_ack, 0);
    step();
    chk("R2 ack one clock after", hold_ack, 1);
    hold_req = 1'b0;
    step();
    chk("R2 ack released", hold_ack, 0);
    step();
  endtask

  task automatic t_clean(input logic [1:0] st, input logic iv, input logic [1:0] exp_ns);
    get_hold();
    snoop(st, iv, 32'h0000_1100, 128'd0);
    step();
    snp_strobe_n = 1'b1;
    chk("R12 hitm high early", hitm_n, 1);
    chk("R12 no report early", nxt_vld, 0);
    step();
    chk("R12 hitm high", hitm_n, 1);
    chk("R12 report valid", nxt_vld, 1);
    chk("R12 next state", nxt_state, exp_ns);
    hold_req = 1'b0; step(); step();
  endtask

  task automatic t_mod_brdy();
    logic [127:0] ln = mk_line(32'hA5A5_0000);
    get_hold();
    snoop(2'b10, 1'b0, 32'h0000_4A3C, ln);
    step();
    snoop(2'b01, 1'b1, 32'h0000_8000, 128'd0);
    chk("R3 hitm not yet", hitm_n, 1);
    step();
    snp_strobe_n = 1'b1;
    chk("R3 hitm low second clock", hitm_n, 0);
    step();
    chk("R4 locked strobe gives no report", nxt_vld, 0);
    chk("R6 no burst while held", ads_n, 1);
    hold_req = 1'b0;
    step();
    chk("R6 ads low", ads_n, 0);
    chk("R6 write", wr, 1);
    chk("R6 cache low", cache_n, 0);
    chk("R6 ack dropped", hold_ack, 0);
    for (int b = 0; b < 4; b++) begin
      chk("R5 R4 beat address", bus_addr, 32'h0000_4A30 + 32'(4 * b));
      chk("R5 beat data", bus_wdata, ln[32*b +: 32]);
      chk("R5 blast", blast_n, (b == 3) ? 1'b0 : 1'b1);
      chk("R7 hitm low in burst", hitm_n, 0);
      if (b == 2) hold_req = 1'b1;
      brdy_n = 1'b0;
      step();
      brdy_n = 1'b1;
    end
    chk("R7 hitm released", hitm_n, 1);
    chk("R11 report valid", nxt_vld, 1);
    chk("R11 shared after inv 0", nxt_state, 2'b01);
    chk("R9 no ack yet", hold_ack, 0);
    chk("R9 bus idle", ads_n, 1);
    step();
    chk("R9 ack after burst", hold_ack, 1);
    hold_req = 1'b0; step(); step();
  endtask

  task automatic t_mod_rdy();
    logic [127:0] ln = mk_line(32'h1234_0000);
    get_hold();
    snoop(2'b10, 1'b1, 32'h0001_00F8, ln);
    step();
    snp_strobe_n = 1'b1;
    step();
    chk("R3 hitm low", hitm_n, 0);
    hold_req = 1'b0;
    step();
    chk("R10 ads low", ads_n, 0);
    for (int b = 0; b < 4; b++) begin
      if (b == 1) hold_req = 1'b1;
      chk("R10 ack held off", hold_ack, 0);
      chk("R10 beat address", bus_addr, 32'h0001_00F0 + 32'(4 * b));
      chk("R10 blast", blast_n, (b == 3) ? 1'b0 : 1'b1);
      rdy_n = 1'b0;
      step();
      rdy_n = 1'b1;
    end
    chk("R10 ack still low", hold_ack, 0);
    chk("R11 invalid after inv 1", nxt_state, 2'b00);
    chk("R11 report valid", nxt_vld, 1);
    step();
    chk("R10 ack after final transfer", hold_ack, 1);
    hold_req = 1'b0; step(); step();
  endtask

  task automatic t_priority();
    get_hold();
    own_req = 1'b1; own_addr = 32'h2000_0010;
    snoop(2'b10, 1'b0, 32'h0000_0300, mk_line(32'hBEEF_0000));
    step();
    snp_strobe_n = 1'b1;
    step();
    chk("R8 hitm low", hitm_n, 0);
    hold_req = 1'b0;
    step();
    chk("R8 write-back first", wr, 1);
    chk("R8 ads low", ads_n, 0);
    for (int b = 0; b < 4; b++) begin
      brdy_n = 1'b0; step(); brdy_n = 1'b1;
    end
    chk("R8 idle clock", ads_n, 1);
    step();
    chk("R8 own ads", ads_n, 0);
    chk("R8 own read", wr, 0);
    chk("R8 own not cacheable", cache_n, 1);
    chk("R8 own blast", blast_n, 0);
    chk("R8 own addr", bus_addr, 32'h2000_0010);
    hold_req = 1'b1;
    step();
    chk("R9 no ack during own", hold_ack, 0);
    brdy_n = 1'b0;
    #1;
    chk("R8 own done", own_done, 1);
    step();
    brdy_n = 1'b1; own_req = 1'b0;
    chk("R9 no ack at completion", hold_ack, 0);
    step();
    chk("R9 ack after own access", hold_ack, 1);
    hold_req = 1'b0; step(); step();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    t_reset();
    t_hold();
    t_clean(2'b00, 1'b0, 2'b00);
    t_clean(2'b01, 1'b0, 2'b01);
    t_clean(2'b01, 1'b1, 2'b00);
    t_mod_brdy();
    t_mod_rdy();
    t_priority();
    done = 1;
    summary();
    $finish;
  end
endmodule